// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block keeps track of which interrupt sources are waiting in each of seven interrupt categories, and picks the one cause that should be delivered next. Every category holds a 64-bit pending vector and a summary flag. Producers post a bit into a category and consumers clear it, both addressed by a category number and a bit index. A single clear-all input wipes everything back to the reset state. A combinational read port returns the whole vector of one category.

The selector looks at the summary flags, the hypervisor flag and the interrupt-enable flag, and reports one cause code. In hypervisor mode only the hypervisor timer match and the interrupt vector categories can be delivered, and only while interrupts are enabled. Outside hypervisor mode the first three categories are delivered whatever the enable flag says. The remaining four are delivered only when interrupts are enabled. For a software interrupt the selector also gives a 4-bit level, derived from the low bits of that category's vector.

Category numbers on the post, clear and read inputs: 0 trap-level-zero, 1 hypervisor timer match, 2 interrupt vector, 3 cross-CPU message, 4 device message, 5 software interrupt, 6 resumable error. Category number 7 is out of range. The cause code is the category number plus one, and 0 means none.

Top module: `irq_pend_arb`

## Requirements
- R1: After rst_n is released, and one cycle after a clr_all pulse, every vector reads zero and cat_pend, any_pend and sel_valid are zero. clr_all overrides a post or a clear issued in the same cycle.
- R2: A post with post_en=1 and post_cat from 0 to 6 sets bit post_idx of that category and its cat_pend bit, both visible from the next cycle.
- R3: A clear with clr_en=1 resets bit clr_idx of category clr_cat. That category's cat_pend bit stays set while any other bit of the vector is still set, and drops in the same cycle the vector becomes zero.
- R4: If a post and a clear name the same category and index in one cycle, the bit ends up set. If they name different bits, both take effect.
- R5: Category number 7 on post_cat or clr_cat changes no state. rd_cat=7 returns zero on rd_vec.
- R6: rd_vec shows the vector of category rd_cat in the same cycle that rd_cat changes, with no clock edge in between.
- R7: any_pend is 1 exactly when some cat_pend bit is set, whatever hyp_mode and int_en are.
- R8: With hyp_mode=1 and int_en=1, the selector reports cause 2 (timer match) first and then cause 3 (interrupt vector). With hyp_mode=1 and int_en=0 it reports nothing. With hyp_mode=1 it never reports any other cause.
- R9: With hyp_mode=0, the selector reports cause 1 (trap-level-zero), then cause 2, then cause 3, whatever int_en is.
- R10: With hyp_mode=0 and int_en=1, if no category that R9 covers is pending, the selector reports cause 4, then 5, then 6 (software), then 7 (resumable error). With int_en=0 these causes are never reported.
- R11: While cause 6 is reported, sel_level is 14 if bit 0 or bit 16 of the software vector is set. Otherwise it is the index of the highest set bit among bits 15 down to 1. Otherwise it is 0.
- R12: sel_level is 0 whenever sel_cause is not 6. When nothing is reported, sel_valid=0 and sel_cause=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| clr_all | input | 1 | Synchronous wipe of all vectors and summary flags |
| post_en | input | 1 | Post request strobe |
| post_cat | input | 3 | Category number for the post |
| post_idx | input | 6 | Bit index for the post |
| clr_en | input | 1 | Clear request strobe |
| clr_cat | input | 3 | Category number for the clear |
| clr_idx | input | 6 | Bit index for the clear |
| rd_cat | input | 3 | Category number for the read port |
| rd_vec | output | 64 | Pending vector of category rd_cat, zero when it is out of range |
| hyp_mode | input | 1 | Processor is in hypervisor mode |
| int_en | input | 1 | Interrupt-enable flag |
| any_pend | output | 1 | Some category has a pending bit |
| cat_pend | output | 7 | Per-category summary flags, bit n for category n |
| sel_valid | output | 1 | A cause is selected for delivery |
| sel_cause | output | 3 | Selected cause code, 0 when none |
| sel_level | output | 4 | Software interrupt level, 0 unless the cause is 6 |

## Verification
A summary flag that has come apart from its vector shows up at the ports in the cycle after the faulty update. Either cat_pend and any_pend stay high while rd_vec for that category reads zero, or the selector skips a category whose vector is visibly non-zero. A wrong bit in a vector is seen on rd_vec the moment that category is selected on the read port. In the software category it also shows as a wrong sel_level. Errors in the priority chain are combinational, so they appear as soon as hyp_mode or int_en is changed over a fixed set of pending categories.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  // Category numbering; cause code = category number + 1
  localparam int NCAT    = 7;
  localparam int CAT_W   = 3;
  localparam int LVL_W   = 4;
  localparam int K_TL0   = 0;
  localparam int K_HVTMR = 1;
  localparam int K_IVEC  = 2;
  localparam int K_XCPU  = 3;
  localparam int K_DEV   = 4;
  localparam int K_SOFT  = 5;
  localparam int K_RERR  = 6;

  // Software level encoding constants
  localparam int SLV_TOP   = 15;  // highest bit scanned for level
  localparam int SLV_ALIAS = 16;  // bit that forces the special level
  localparam int SLV_SPEC  = 14;  // special level value
  localparam int SLV_W     = SLV_ALIAS + 1;

  typedef enum logic [CAT_W-1:0] {
    CZ_NONE  = 3'd0,
    CZ_TL0   = 3'd1,
    CZ_HVTMR = 3'd2,
    CZ_IVEC  = 3'd3,
    CZ_XCPU  = 3'd4,
    CZ_DEV   = 3'd5,
    CZ_SOFT  = 3'd6,
    CZ_RERR  = 3'd7
  } cause_e;
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ipc_bank.sv
module ipc_bank #(
  parameter int VEC_W = 64,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             set_hit,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_hit,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [VEC_W-1:0] vec,
  output logic             busy
);
  logic [VEC_W-1:0] vec_q, vec_nxt;
  logic             sum_q, sum_nxt;
  logic             upd_en;

  // Next-state: clear first, post overrides, wipe overrides all
  always_comb begin
    vec_nxt = vec_q;
    if (clr_hit) vec_nxt[clr_idx] = 1'b0;
    if (set_hit) vec_nxt[set_idx] = 1'b1;
    if (clr_all) vec_nxt = '0;
  end

  // Summary: set by a post, dropped only when the vector empties
  always_comb begin
    if (clr_all)      sum_nxt = 1'b0;
    else if (set_hit) sum_nxt = 1'b1;
    else              sum_nxt = sum_q & (vec_nxt != '0);
  end

  assign upd_en = clr_all | set_hit | clr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      sum_q <= 1'b0;
    end else if (upd_en) begin
      vec_q <= vec_nxt;
      sum_q <= sum_nxt;
    end
  end

  assign vec  = vec_q;
  assign busy = sum_q;
endmodule

// File: rtl/ipc_soft_lvl.sv
module ipc_soft_lvl
  import ipc_pkg::*;
(
  input  logic [SLV_W-1:0] low_bits,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    // ascending scan so the highest set bit is kept
    for (int b = 1; b <= SLV_TOP; b++) begin
      if (low_bits[b]) level = LVL_W'(b);
    end
    if (low_bits[0] | low_bits[SLV_ALIAS]) level = LVL_W'(SLV_SPEC);
  end
endmodule

// File: rtl/ipc_select.sv
module ipc_select
  import ipc_pkg::*;
(
  input  logic [NCAT-1:0]  pend,
  input  logic [LVL_W-1:0] soft_lvl,
  input  logic             hyp,
  input  logic             ien,
  output logic             valid,
  output logic [CAT_W-1:0] cause,
  output logic [LVL_W-1:0] level
);
  cause_e pick;

  always_comb begin
    pick = CZ_NONE;
    if (hyp) begin
      if (ien) begin
        if      (pend[K_HVTMR]) pick = CZ_HVTMR;
        else if (pend[K_IVEC])  pick = CZ_IVEC;
      end
    end else begin
      if      (pend[K_TL0])   pick = CZ_TL0;
      else if (pend[K_HVTMR]) pick = CZ_HVTMR;
      else if (pend[K_IVEC])  pick = CZ_IVEC;
      else if (ien) begin
        if      (pend[K_XCPU]) pick = CZ_XCPU;
        else if (pend[K_DEV])  pick = CZ_DEV;
        else if (pend[K_SOFT]) pick = CZ_SOFT;
        else if (pend[K_RERR]) pick = CZ_RERR;
      end
    end
  end

  assign valid = (pick != CZ_NONE);
  assign cause = pick;
  assign level = (pick == CZ_SOFT) ? soft_lvl : '0;
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
  import ipc_pkg::*;
#(
  parameter int VEC_W = 64,
  localparam int IDX_W = $clog2(VEC_W),
  localparam int FLAT_W = NCAT * VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             post_en,
  input  logic [CAT_W-1:0] post_cat,
  input  logic [IDX_W-1:0] post_idx,
  input  logic             clr_en,
  input  logic [CAT_W-1:0] clr_cat,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [CAT_W-1:0] rd_cat,
  output logic [VEC_W-1:0] rd_vec,
  input  logic             hyp_mode,
  input  logic             int_en,
  output logic             any_pend,
  output logic [NCAT-1:0]  cat_pend,
  output logic             sel_valid,
  output logic [CAT_W-1:0] sel_cause,
  output logic [LVL_W-1:0] sel_level
);
  logic              rst_sync_n;
  logic [VEC_W-1:0]  vecs [NCAT];
  logic [FLAT_W-1:0] vec_flat;
  logic [LVL_W-1:0]  soft_lvl;

  ipc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NCAT; c++) begin : g_cat
    logic set_hit, clr_hit;
    assign set_hit = post_en && (post_cat == CAT_W'(c));
    assign clr_hit = clr_en  && (clr_cat  == CAT_W'(c));

    ipc_bank #(.VEC_W(VEC_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr_all (clr_all),
      .set_hit (set_hit),
      .set_idx (post_idx),
      .clr_hit (clr_hit),
      .clr_idx (clr_idx),
      .vec     (vecs[c]),
      .busy    (cat_pend[c])
    );

    assign vec_flat[c*VEC_W +: VEC_W] = vecs[c];
  end

  // Read port: out-of-range category returns zero
  always_comb begin
    rd_vec = '0;
    for (int c = 0; c < NCAT; c++) begin
      if (rd_cat == CAT_W'(c)) rd_vec = vecs[c];
    end
  end

  assign any_pend = |cat_pend;

  ipc_soft_lvl u_lvl (
    .low_bits (vecs[K_SOFT][SLV_W-1:0]),
    .level    (soft_lvl)
  );

  ipc_select u_sel (
    .pend     (cat_pend),
    .soft_lvl (soft_lvl),
    .hyp      (hyp_mode),
    .ien      (int_en),
    .valid    (sel_valid),
    .cause    (sel_cause),
    .level    (sel_level)
  );
endmodule

// File: rtl/irq_pend_arb_chk.sv
module irq_pend_arb_chk
  import ipc_pkg::*;
#(
  parameter int VEC_W = 64,
  localparam int IDX_W = $clog2(VEC_W),
  localparam int FLAT_W = NCAT * VEC_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              clr_all,
  input logic              post_en,
  input logic [CAT_W-1:0]  post_cat,
  input logic [IDX_W-1:0]  post_idx,
  input logic              hyp_mode,
  input logic              int_en,
  input logic              any_pend,
  input logic [NCAT-1:0]   cat_pend,
  input logic              sel_valid,
  input logic [CAT_W-1:0]  sel_cause,
  input logic [LVL_W-1:0]  sel_level,
  input logic [FLAT_W-1:0] vec_flat
);
  // R1: a wipe empties every summary flag
  assert_clrall_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_all |=> (cat_pend == '0));

  // R2: a valid post sets the bit and the summary flag
  assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (post_en && !clr_all && (post_cat < CAT_W'(NCAT)))
    |=> (cat_pend[$past(post_cat)] &&
         vec_flat[$past(post_cat) * VEC_W + $past(post_idx)]));

  // R3: summary flag agrees with its own vector register
  for (genvar c = 0; c < NCAT; c++) begin : g_sum
    assert_sum_tracks_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      cat_pend[c] == (vec_flat[c*VEC_W +: VEC_W] != '0));
  end

  // R7: a delivered cause implies something pending
  assert_valid_any_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_valid |-> any_pend);

  // R8: hypervisor mode masks all when disabled, and limits the causes
  assert_hyp_masked_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hyp_mode && !int_en) |-> !sel_valid);
  assert_hyp_subset_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hyp_mode && sel_valid) |-> (sel_cause == 3'd2 || sel_cause == 3'd3));

  // R9: trap-level-zero wins outside hypervisor mode
  assert_tl0_first_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!hyp_mode && cat_pend[K_TL0]) |-> (sel_valid && sel_cause == 3'd1));

  // R10: enable-gated causes stay hidden when disabled
  assert_gated_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!int_en) |-> (sel_cause < 3'd4));

  // R12: level quiet unless software cause; none means code zero
  assert_level_quiet_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_cause != 3'd6) |-> (sel_level == '0));
  assert_none_zero_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sel_valid |-> (sel_cause == 3'd0));
endmodule

bind irq_pend_arb irq_pend_arb_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .clr_all    (clr_all),
  .post_en    (post_en),
  .post_cat   (post_cat),
  .post_idx   (post_idx),
  .hyp_mode   (hyp_mode),
  .int_en     (int_en),
  .any_pend   (any_pend),
  .cat_pend   (cat_pend),
  .sel_valid  (sel_valid),
  .sel_cause  (sel_cause),
  .sel_level  (sel_level),
  .vec_flat   (vec_flat)
);

// File: tb/irq_pend_arb_tb.sv
module irq_pend_arb_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_all, post_en, clr_en, hyp_mode, int_en;
  logic [2:0]  post_cat, clr_cat, rd_cat;
  logic [5:0]  post_idx, clr_idx;
  logic [63:0] rd_vec;
  logic        any_pend, sel_valid;
  logic [6:0]  cat_pend;
  logic [2:0]  sel_cause;
  logic [3:0]  sel_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_pend_arb u_dut (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .post_en(post_en), .post_cat(post_cat), .post_idx(post_idx),
    .clr_en(clr_en), .clr_cat(clr_cat), .clr_idx(clr_idx),
    .rd_cat(rd_cat), .rd_vec(rd_vec),
    .hyp_mode(hyp_mode), .int_en(int_en),
    .any_pend(any_pend), .cat_pend(cat_pend),
    .sel_valid(sel_valid), .sel_cause(sel_cause), .sel_level(sel_level)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [2:0] c, input logic [63:0] exp);
    rd_cat = c;
    #1;
    chk(req, rd_vec, exp);
  endtask

  task automatic chk_sel(input string req, input logic h, input logic e,
                         input logic v, input logic [2:0] cz, input logic [3:0] lv);
    hyp_mode = h;
    int_en   = e;
    #1;
    chk(req, {56'd0, sel_valid, sel_cause, sel_level}, {56'd0, v, cz, lv});
  endtask

  // one cycle with any mix of operations
  task automatic cyc(input logic pe, input logic [2:0] pc, input logic [5:0] pi,
                     input logic ce, input logic [2:0] cc, input logic [5:0] ci,
                     input logic wipe);
    @(negedge clk);
    post_en = pe; post_cat = pc; post_idx = pi;
    clr_en  = ce; clr_cat  = cc; clr_idx  = ci;
    clr_all = wipe;
    @(negedge clk);
    post_en = 1'b0; clr_en = 1'b0; clr_all = 1'b0;
  endtask

  task automatic do_post(input logic [2:0] c, input logic [5:0] i);
    cyc(1'b1, c, i, 1'b0, 3'd0, 6'd0, 1'b0);
  endtask

  task automatic do_clr(input logic [2:0] c, input logic [5:0] i);
    cyc(1'b0, 3'd0, 6'd0, 1'b1, c, i, 1'b0);
  endtask

  task automatic do_wipe();
    cyc(1'b0, 3'd0, 6'd0, 1'b0, 3'd0, 6'd0, 1'b1);
  endtask

  task automatic t_reset();
    for (int c = 0; c < 8; c++) chk_rd("R1 reset vector", 3'(c), 64'd0);
    chk("R1 reset cat_pend", {57'd0, cat_pend}, 64'd0);
    chk("R1 reset any_pend", {63'd0, any_pend}, 64'd0);
    chk_sel("R12 reset none", 1'b0, 1'b1, 1'b0, 3'd0, 4'd0);
  endtask

  task automatic t_post_clear();
    do_post(3'd3, 6'd5);
    do_post(3'd3, 6'd40);
    chk_rd("R2 post two bits", 3'd3, (64'd1 << 5) | (64'd1 << 40));
    chk("R2 summary set", {57'd0, cat_pend}, 64'h08);
    chk_sel("R7 any_pend while masked", 1'b1, 1'b0, 1'b0, 3'd0, 4'd0);
    chk("R7 any_pend hyp", {63'd0, any_pend}, 64'd1);
    chk_sel("R8 hyp ignores cross-CPU", 1'b1, 1'b1, 1'b0, 3'd0, 4'd0);
    do_clr(3'd3, 6'd5);
    chk_rd("R3 one bit left", 3'd3, 64'd1 << 40);
    chk("R3 summary held", {57'd0, cat_pend}, 64'h08);
    do_clr(3'd3, 6'd40);
    chk("R3 summary dropped", {57'd0, cat_pend}, 64'h00);
    chk("R7 any_pend low", {63'd0, any_pend}, 64'd0);
  endtask

  task automatic t_same_cycle();
    cyc(1'b1, 3'd2, 6'd7, 1'b1, 3'd2, 6'd7, 1'b0);
    chk_rd("R4 post wins", 3'd2, 64'd1 << 7);
    cyc(1'b1, 3'd2, 6'd8, 1'b1, 3'd2, 6'd7, 1'b0);
    chk_rd("R4 both apply", 3'd2, 64'd1 << 8);
    rd_cat = 3'd2;
    #1;
    chk("R6 read follows rd_cat", rd_vec, 64'd1 << 8);
    rd_cat = 3'd0;
    #1;
    chk("R6 read switches", rd_vec, 64'd0);
  endtask

  task automatic t_bad_cat();
    do_post(3'd7, 6'd8);
    chk("R5 post cat7 ignored", {57'd0, cat_pend}, 64'h04);
    do_clr(3'd7, 6'd8);
    chk_rd("R5 clear cat7 ignored", 3'd2, 64'd1 << 8);
    chk_rd("R5 read cat7 zero", 3'd7, 64'd0);
    do_wipe();
  endtask

  task automatic t_priority();
    for (int c = 0; c < 7; c++) do_post(3'(c), 6'(c * 9));
    chk_sel("R9 tl0 first en", 1'b0, 1'b1, 1'b1, 3'd1, 4'd0);
    chk_sel("R9 tl0 first dis", 1'b0, 1'b0, 1'b1, 3'd1, 4'd0);
    chk_sel("R8 hyp timer", 1'b1, 1'b1, 1'b1, 3'd2, 4'd0);
    do_clr(3'd0, 6'd0);
    chk_sel("R9 timer second", 1'b0, 1'b0, 1'b1, 3'd2, 4'd0);
    chk_sel("R8 hyp disabled", 1'b1, 1'b0, 1'b0, 3'd0, 4'd0);
    do_clr(3'd1, 6'd9);
    chk_sel("R8 hyp vector", 1'b1, 1'b1, 1'b1, 3'd3, 4'd0);
    chk_sel("R9 vector ignores enable", 1'b0, 1'b0, 1'b1, 3'd3, 4'd0);
    do_clr(3'd2, 6'd18);
    chk_sel("R8 hyp nothing else", 1'b1, 1'b1, 1'b0, 3'd0, 4'd0);
    chk_sel("R10 disabled hides", 1'b0, 1'b0, 1'b0, 3'd0, 4'd0);
    chk_sel("R10 cross-CPU", 1'b0, 1'b1, 1'b1, 3'd4, 4'd0);
    do_clr(3'd3, 6'd27);
    chk_sel("R10 device", 1'b0, 1'b1, 1'b1, 3'd5, 4'd0);
    do_clr(3'd4, 6'd36);
    chk_sel("R10 software bit45", 1'b0, 1'b1, 1'b1, 3'd6, 4'd0);
    do_clr(3'd5, 6'd45);
    chk_sel("R10 resumable", 1'b0, 1'b1, 1'b1, 3'd7, 4'd0);
    chk_sel("R12 level quiet", 1'b0, 1'b1, 1'b1, 3'd7, 4'd0);
    do_wipe();
  endtask

  task automatic lvl_case(input string req, input logic [63:0] pat, input logic [3:0] lv);
    do_wipe();
    for (int b = 0; b < 64; b++) if (pat[b]) do_post(3'd5, 6'(b));
    chk_sel(req, 1'b0, 1'b1, 1'b1, 3'd6, lv);
  endtask

  task automatic t_level();
    lvl_case("R11 bit16 alias", 64'h0001_0000, 4'd14);
    lvl_case("R11 bit0 over bit15", 64'h0000_8001, 4'd14);
    lvl_case("R11 bit15", 64'h0000_8000, 4'd15);
    lvl_case("R11 highest of 9,3", 64'h0000_0208, 4'd9);
    lvl_case("R11 bit1", 64'h0000_0002, 4'd1);
    lvl_case("R11 high only", 64'h0000_0100_0000_0000, 4'd0);
    do_wipe();
  endtask

  task automatic t_wipe();
    do_post(3'd1, 6'd63);
    do_post(3'd6, 6'd0);
    cyc(1'b1, 3'd4, 6'd2, 1'b0, 3'd0, 6'd0, 1'b1);
    chk("R1 wipe beats post", {57'd0, cat_pend}, 64'd0);
    chk_rd("R1 wipe vector", 3'd1, 64'd0);
    chk_rd("R1 wipe posted cat", 3'd4, 64'd0);
    chk_sel("R1 wipe no cause", 1'b0, 1'b1, 1'b0, 3'd0, 4'd0);
  endtask

  initial begin
    rst_n = 1'b0; clr_all = 1'b0; post_en = 1'b0; clr_en = 1'b0;
    post_cat = '0; post_idx = '0; clr_cat = '0; clr_idx = '0;
    rd_cat = '0; hyp_mode = 1'b0; int_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_post_clear();
    t_same_cycle();
    t_bad_cat();
    t_priority();
    t_level();
    t_wipe();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule